// File: doc/BRIEF.md
# Load/Store Effective-Address and Load-Format Unit

This unit sits between a core's register read stage and its data memory port. For every load or store it forms the byte address from a base value and an offset. The offset can be a short immediate, an index register, or an index register shifted left. The unit then decides whether, and with what value, the base register is updated. It drives a single outstanding request onto a synchronous memory port and holds that request until the memory answers.

On a load it takes the returned word and builds the register value. It picks the byte lane or lanes that the low address bits select. It puts them in the byte order that was fixed when reset was released, and then zero- or sign-extends a narrow result. All results, including the base update, are presented in the single cycle in which the memory acknowledges. The core can therefore write both in one step. If a load names the same register as its written-back base, the loaded value wins and a flag reports the clash.

Top module: `lsu_addr_unit`

## Requirements
- R1: With op_mode = 0 (offset), or the spare code 3, mem_addr is op_base plus or minus the offset, taken modulo 2^AW, and wb_en stays low for the whole operation.
- R2: With op_mode = 1 (pre-indexed), mem_addr is op_base plus or minus the offset. At commit, wb_en is high and wb_value equals that same address, with wb_reg = op_base_reg.
- R3: With op_mode = 2 (post-indexed), mem_addr is the unmodified op_base. At commit, wb_en is high and wb_value is op_base plus or minus the offset.
- R4: op_off_src = 0 selects op_imm zero-extended, 1 selects op_index, and 2 or 3 selects op_index shifted left by op_shamt. op_sub = 1 subtracts the offset and op_sub = 0 adds it.
- R5: A byte load (op_size = 0) returns the selected byte in ld_data[7:0]. If op_signed = 0 the upper bits are zero. If op_signed = 1 every upper bit copies bit 7 of the byte.
- R6: A halfword load (op_size = 1) returns 16 bits in ld_data[15:0], zero-extended or sign-extended from bit 15 in the same way. Codes 2 and 3 load a full word.
- R7: Lane k of mem_rdata (bits 8k+7:8k) holds the byte at word offset k. A byte comes from lane mem_addr[1:0]. A halfword uses lanes o and o+1, with o = mem_addr[1:0] with bit 0 cleared; lane o+1 is the upper byte in little-endian and lane o is the upper byte in big-endian. A big-endian word puts lane 0 in bits 31:24 and lane 3 in bits 7:0. A little-endian word is mem_rdata unchanged.
- R8: Byte order is cfg_big_endian as sampled at the first clock edge after rst_n rises (1 = big-endian). Later changes of cfg_big_endian have no effect until the next reset. op_ready stays low until that edge.
- R9: An operation is accepted on a clock edge where op_valid and op_ready are both high. From the next cycle mem_req is high, and mem_addr, mem_size (the op_size code) and mem_write (1 for a store) stay constant until the cycle in which mem_ready is high. During that time op_ready is low.
- R10: wb_en and ld_en are high only in the cycle where mem_req and mem_ready are both high. ld_en is high only for loads, and a store never produces ld_en.
- R11: If a load needs writeback and op_dst_reg equals op_base_reg, then at commit ld_en is high, wb_en is low and wb_conflict is high. Without writeback, or on a store, wb_conflict stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_endian | input | 1 | Byte-order strap, sampled once after reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit can accept an operation |
| op_load | input | 1 | 1 load, 0 store |
| op_mode | input | 2 | Addressing mode: 0 offset, 1 pre-indexed, 2 post-indexed |
| op_off_src | input | 2 | Offset source: 0 immediate, 1 index, 2/3 shifted index |
| op_sub | input | 1 | 1 subtracts the offset from the base |
| op_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| op_signed | input | 1 | Sign-extend narrow loads |
| op_base | input | AW | Base register value |
| op_index | input | AW | Index register value |
| op_imm | input | IMMW | Immediate offset |
| op_shamt | input | SHW | Left shift applied to the index |
| op_base_reg | input | RW | Base register number |
| op_dst_reg | input | RW | Load destination register number |
| mem_req | output | 1 | Memory request pending |
| mem_write | output | 1 | Pending request is a store |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Size code of the access |
| mem_ready | input | 1 | Memory completes the pending request |
| mem_rdata | input | DW | Aligned word read from memory |
| wb_en | output | 1 | Base register write this cycle |
| wb_reg | output | RW | Base register number to write |
| wb_value | output | AW | New base value |
| ld_en | output | 1 | Load result write this cycle |
| ld_reg | output | RW | Load destination register number |
| ld_data | output | DW | Aligned, reordered and extended load value |
| wb_conflict | output | 1 | Load and writeback target the same register |

## Verification
The bench builds the unit with a 4-bit immediate and keeps the default 32-bit address and data widths, a 5-bit shift amount and 4-bit register numbers. With that immediate width every offset value the immediate path can form is reachable by a simple sweep. The bench sweeps every mode, offset source, add/subtract choice, size, signedness and byte lane, once under each byte order and with memory waits of zero to two cycles. Separate cases reach the register clash, the spare encodings, wrap-around of the address sum, and a strap change after reset.

// File: rtl/lsu_addr_pkg.sv
package lsu_addr_pkg;

  typedef enum logic [1:0] {
    AM_OFFSET = 2'd0,
    AM_PRE    = 2'd1,
    AM_POST   = 2'd2,
    AM_SPARE  = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    OS_IMM      = 2'd0,
    OS_INDEX    = 2'd1,
    OS_SHIFT    = 2'd2,
    OS_SHIFT_B  = 2'd3
  } off_src_e;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_WORD_B = 2'd3
  } acc_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } port_state_e;

endpackage

// File: rtl/lsu_offset_gen.sv
module lsu_offset_gen
  import lsu_addr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IMMW = 12,
  parameter int SHW  = 5
) (
  input  off_src_e          src,
  input  logic [IMMW-1:0]   imm,
  input  logic [AW-1:0]     index,
  input  logic [SHW-1:0]    shamt,
  output logic [AW-1:0]     offset
);

  localparam int PADW = AW - IMMW;

  logic [AW-1:0] imm_ext;
  logic [AW-1:0] idx_shifted;

  generate
    if (PADW > 0) begin : g_pad
      assign imm_ext = {{PADW{1'b0}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[AW-1:0];
    end
  endgenerate

  assign idx_shifted = index << shamt;

  always_comb begin
    unique case (src)
      OS_IMM:   offset = imm_ext;
      OS_INDEX: offset = index;
      default:  offset = idx_shifted;
    endcase
  end

endmodule

// File: rtl/lsu_addr_calc.sv
module lsu_addr_calc
  import lsu_addr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic          sub,
  input  addr_mode_e    mode,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] upd_value,
  output logic          upd_need
);

  logic [AW-1:0] moved;

  assign moved = sub ? (base - offset) : (base + offset);

  always_comb begin
    eff_addr  = moved;
    upd_value = moved;
    upd_need  = 1'b0;
    unique case (mode)
      AM_PRE: begin
        upd_need = 1'b1;
      end
      AM_POST: begin
        eff_addr = base;
        upd_need = 1'b1;
      end
      default: begin
        upd_value = base;
      end
    endcase
  end

endmodule

// File: rtl/lsu_load_format.sv
module lsu_load_format
  import lsu_addr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]          rdata,
  input  logic [$clog2(DW/8)-1:0] lane,
  input  acc_size_e              size,
  input  logic                   sgn,
  input  logic                   big,
  output logic [DW-1:0]          data
);

  localparam int NLANE = DW / 8;
  localparam int LW    = $clog2(NLANE);

  logic [7:0]    lane_b [NLANE];
  logic [DW-1:0] word_rev;
  logic [7:0]    pick_b;
  logic [15:0]   pick_h;
  logic [LW-1:0] h_lo;
  logic [LW-1:0] h_hi;

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign lane_b[g]             = rdata[8*g +: 8];
      assign word_rev[8*g +: 8]    = lane_b[NLANE-1-g];
    end
  endgenerate

  assign h_lo   = {lane[LW-1:1], 1'b0};
  assign h_hi   = {lane[LW-1:1], 1'b1};
  assign pick_b = lane_b[lane];
  assign pick_h = big ? {lane_b[h_lo], lane_b[h_hi]}
                      : {lane_b[h_hi], lane_b[h_lo]};

  always_comb begin
    unique case (size)
      SZ_BYTE: data = sgn ? {{(DW-8){pick_b[7]}}, pick_b}
                          : {{(DW-8){1'b0}}, pick_b};
      SZ_HALF: data = sgn ? {{(DW-16){pick_h[15]}}, pick_h}
                          : {{(DW-16){1'b0}}, pick_h};
      default: data = big ? word_rev : rdata;
    endcase
  end

endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
  import lsu_addr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int IMMW = 12,
  parameter int SHW  = 5,
  parameter int RW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_big_endian,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic            op_load,
  input  logic [1:0]      op_mode,
  input  logic [1:0]      op_off_src,
  input  logic            op_sub,
  input  logic [1:0]      op_size,
  input  logic            op_signed,
  input  logic [AW-1:0]   op_base,
  input  logic [AW-1:0]   op_index,
  input  logic [IMMW-1:0] op_imm,
  input  logic [SHW-1:0]  op_shamt,
  input  logic [RW-1:0]   op_base_reg,
  input  logic [RW-1:0]   op_dst_reg,
  output logic            mem_req,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_size,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic            wb_en,
  output logic [RW-1:0]   wb_reg,
  output logic [AW-1:0]   wb_value,
  output logic            ld_en,
  output logic [RW-1:0]   ld_reg,
  output logic [DW-1:0]   ld_data,
  output logic            wb_conflict
);

  localparam int LW = $clog2(DW/8);

  // ---------------------------------------------------------------
  // Address datapath
  // ---------------------------------------------------------------
  logic [AW-1:0] offset;
  logic [AW-1:0] eff_addr;
  logic [AW-1:0] upd_value;
  logic          upd_need;

  lsu_offset_gen #(.AW(AW), .IMMW(IMMW), .SHW(SHW)) u_off (
    .src    (off_src_e'(op_off_src)),
    .imm    (op_imm),
    .index  (op_index),
    .shamt  (op_shamt),
    .offset (offset)
  );

  lsu_addr_calc #(.AW(AW)) u_calc (
    .base      (op_base),
    .offset    (offset),
    .sub       (op_sub),
    .mode      (addr_mode_e'(op_mode)),
    .eff_addr  (eff_addr),
    .upd_value (upd_value),
    .upd_need  (upd_need)
  );

  // ---------------------------------------------------------------
  // State
  // ---------------------------------------------------------------
  port_state_e   state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] upd_q, upd_d;
  logic          need_q, need_d;
  logic          load_q, load_d;
  acc_size_e     size_q, size_d;
  logic          sgn_q, sgn_d;
  logic [RW-1:0] breg_q, breg_d;
  logic [RW-1:0] dreg_q, dreg_d;
  logic          big_q, big_d;
  logic          strap_done_q, strap_done_d;

  logic accept;
  logic commit;
  logic clash;

  assign op_ready = (state_q == ST_IDLE) && strap_done_q;
  assign accept   = op_valid && op_ready;
  assign commit   = (state_q == ST_WAIT) && mem_ready;
  assign clash    = load_q && need_q && (dreg_q == breg_q);

  // Strap capture: once, on the first edge after reset release.
  always_comb begin
    strap_done_d = strap_done_q;
    big_d        = big_q;
    if (!strap_done_q) begin
      strap_done_d = 1'b1;
      big_d        = cfg_big_endian;
    end
  end

  // Request capture and port state.
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    upd_d   = upd_q;
    need_d  = need_q;
    load_d  = load_q;
    size_d  = size_q;
    sgn_d   = sgn_q;
    breg_d  = breg_q;
    dreg_d  = dreg_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_WAIT;
          addr_d  = eff_addr;
          upd_d   = upd_value;
          need_d  = upd_need;
          load_d  = op_load;
          size_d  = acc_size_e'(op_size);
          sgn_d   = op_signed;
          breg_d  = op_base_reg;
          dreg_d  = op_dst_reg;
        end
      end
      default: begin
        if (mem_ready) begin
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done_q <= 1'b0;
      big_q        <= 1'b0;
    end else if (!strap_done_q) begin
      strap_done_q <= strap_done_d;
      big_q        <= big_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      upd_q  <= '0;
      need_q <= 1'b0;
      load_q <= 1'b0;
      size_q <= SZ_BYTE;
      sgn_q  <= 1'b0;
      breg_q <= '0;
      dreg_q <= '0;
    end else if (accept) begin
      addr_q <= addr_d;
      upd_q  <= upd_d;
      need_q <= need_d;
      load_q <= load_d;
      size_q <= size_d;
      sgn_q  <= sgn_d;
      breg_q <= breg_d;
      dreg_q <= dreg_d;
    end
  end

  // ---------------------------------------------------------------
  // Memory port and results
  // ---------------------------------------------------------------
  logic [DW-1:0] fmt_data;

  lsu_load_format #(.DW(DW)) u_fmt (
    .rdata (mem_rdata),
    .lane  (addr_q[LW-1:0]),
    .size  (size_q),
    .sgn   (sgn_q),
    .big   (big_q),
    .data  (fmt_data)
  );

  assign mem_req     = (state_q == ST_WAIT);
  assign mem_write   = mem_req && !load_q;
  assign mem_addr    = addr_q;
  assign mem_size    = size_q;

  assign ld_en       = commit && load_q;
  assign ld_reg      = dreg_q;
  assign ld_data     = ld_en ? fmt_data : '0;
  assign wb_en       = commit && need_q && !clash;
  assign wb_reg      = breg_q;
  assign wb_value    = wb_en ? upd_q : '0;
  assign wb_conflict = commit && clash;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  p_hold_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)
                                 && $stable(mem_write)));

  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !op_ready);

  p_commit_on_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en || ld_en) |-> (mem_req && mem_ready));

  p_store_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |-> !ld_en);

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_conflict |-> (ld_en && !wb_en && (ld_reg == wb_reg)));

  p_strap_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done_q |=> ($stable(big_q) && strap_done_q));

  p_ubyte_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && size_q == SZ_BYTE && !sgn_q) |-> (ld_data[DW-1:8] == '0));

  p_shalf_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && size_q == SZ_HALF && sgn_q) |->
      (ld_data[DW-1:16] == {(DW-16){ld_data[15]}}));

endmodule

// File: tb/tb_lsu_addr_unit.sv
module tb_lsu_addr_unit;

  localparam int AW = 32, DW = 32, IMMW = 4, SHW = 5, RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_big_endian = 1'b0;
  logic op_valid = 1'b0, op_ready, op_load = 1'b0, op_sub = 1'b0, op_signed = 1'b0;
  logic [1:0] op_mode = '0, op_off_src = '0, op_size = '0;
  logic [AW-1:0] op_base = '0, op_index = '0;
  logic [IMMW-1:0] op_imm = '0;
  logic [SHW-1:0] op_shamt = '0;
  logic [RW-1:0] op_base_reg = '0, op_dst_reg = '0;
  logic mem_req, mem_write, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [DW-1:0] mem_rdata = '0;
  logic wb_en, ld_en, wb_conflict;
  logic [RW-1:0] wb_reg, ld_reg;
  logic [AW-1:0] wb_value;
  logic [DW-1:0] ld_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsu_addr_unit #(.AW(AW), .DW(DW), .IMMW(IMMW), .SHW(SHW), .RW(RW)) dut (
    .clk, .rst_n, .cfg_big_endian, .op_valid, .op_ready, .op_load, .op_mode,
    .op_off_src, .op_sub, .op_size, .op_signed, .op_base, .op_index, .op_imm,
    .op_shamt, .op_base_reg, .op_dst_reg, .mem_req, .mem_write, .mem_addr,
    .mem_size, .mem_ready, .mem_rdata, .wb_en, .wb_reg, .wb_value, .ld_en,
    .ld_reg, .ld_data, .wb_conflict
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_load(input logic [31:0] rd, input logic [1:0] ln,
                                           input logic [1:0] sz, input bit sg, input bit be);
    logic [7:0] b [4];
    logic [31:0] v;
    int o;
    for (int k = 0; k < 4; k++) b[k] = rd[8*k +: 8];
    if (sz == 2'd0) begin
      v = {24'h0, b[ln]};
      if (sg && v[7]) v[31:8] = 24'hFFFFFF;
    end else if (sz == 2'd1) begin
      o = (ln >= 2) ? 2 : 0;
      v = be ? {16'h0, b[o], b[o+1]} : {16'h0, b[o+1], b[o]};
      if (sg && v[15]) v[31:16] = 16'hFFFF;
    end else begin
      v = be ? {b[0], b[1], b[2], b[3]} : rd;
    end
    return v;
  endfunction

  task automatic do_reset(input bit be);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_big_endian = be;
    op_valid = 1'b0;
    mem_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(!mem_req && !wb_en && !ld_en && !op_ready && !wb_conflict, "R9 reset idle",
        {28'h0, mem_req, wb_en, ld_en, op_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(op_ready, "R8 ready after strap edge", {31'h0, op_ready}, 32'h1);
  endtask

  task automatic do_op(input bit ld, input logic [1:0] md, input logic [1:0] src,
                       input bit sb, input logic [1:0] sz, input bit sg,
                       input logic [31:0] base, input logic [31:0] idx,
                       input logic [IMMW-1:0] imm, input logic [SHW-1:0] sh,
                       input logic [RW-1:0] br, input logic [RW-1:0] dr,
                       input logic [31:0] rd, input int lat, input bit be);
    logic [31:0] off, sum, ea, el;
    bit need, clash;
    string mreq;
    off   = (src == 2'd0) ? {28'h0, imm} : (src == 2'd1) ? idx : (idx << sh);
    sum   = sb ? base - off : base + off;
    ea    = (md == 2'd2) ? base : sum;
    need  = (md == 2'd1) || (md == 2'd2);
    clash = ld && need && (br == dr);
    mreq  = (md == 2'd1) ? "R2" : (md == 2'd2) ? "R3" : "R1";
    el    = exp_load(rd, ea[1:0], sz, sg, be);

    @(negedge clk);
    op_valid = 1'b1; op_load = ld; op_mode = md; op_off_src = src; op_sub = sb;
    op_size = sz; op_signed = sg; op_base = base; op_index = idx; op_imm = imm;
    op_shamt = sh; op_base_reg = br; op_dst_reg = dr;
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    chk(mem_addr == ea, {mreq, " R4 address"}, mem_addr, ea);
    chk(mem_req && mem_size == sz && mem_write == !ld && !op_ready, "R9 request",
        {27'h0, mem_req, mem_size, mem_write, op_ready}, {27'h0, 1'b1, sz, !ld, 1'b0});
    for (int w = 0; w < lat; w++) begin
      @(negedge clk);
      #1;
      chk(mem_req && mem_addr == ea && !op_ready, "R9 hold", mem_addr, ea);
      chk(!wb_en && !ld_en, "R10 no early commit", {30'h0, wb_en, ld_en}, 32'h0);
    end
    mem_ready = 1'b1;
    mem_rdata = rd;
    #1;
    chk(wb_en == (need && !clash), {mreq, " writeback enable"}, {31'h0, wb_en},
        {31'h0, need && !clash});
    if (need && !clash)
      chk(wb_value == sum && wb_reg == br, {mreq, " writeback value"}, wb_value, sum);
    chk(ld_en == ld, "R10 load enable", {31'h0, ld_en}, {31'h0, ld});
    if (ld) begin
      chk(ld_data == el && ld_reg == dr,
          (sz == 2'd0) ? "R5 R7 byte" : (sz == 2'd1) ? "R6 R7 half" : "R7 word",
          ld_data, el);
    end
    chk(wb_conflict == clash, "R11 conflict flag", {31'h0, wb_conflict}, {31'h0, clash});
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  initial begin : main
    int n;
    n = 0;
    for (int be = 0; be < 2; be++) begin
      do_reset(be[0]);
      for (int md = 0; md < 3; md++)
        for (int src = 0; src < 3; src++)
          for (int sb = 0; sb < 2; sb++)
            for (int sz = 0; sz < 3; sz++)
              for (int sg = 0; sg < 2; sg++)
                for (int ln = 0; ln < 4; ln++) begin
                  n++;
                  do_op(ln != 3, md[1:0], src[1:0], sb[0], sz[1:0], sg[0],
                        32'h2000_0040 + ln * 5 + n * 16, 32'h0000_0100 + n,
                        IMMW'(n), SHW'(n % 7), 4'd1, 4'd2,
                        32'h80F1_7E05 ^ (n * 32'h9E37_79B9), n % 3, be[0]);
                end
    end
    // R8: strap changes after reset are ignored (still big-endian here)
    cfg_big_endian = 1'b0;
    do_op(1, 2'd0, 2'd0, 0, 2'd2, 0, 32'h100, 0, 4'd0, 0, 4'd1, 4'd2,
          32'h1122_3344, 0, 1'b1);
    do_reset(1'b0);
    cfg_big_endian = 1'b1;
    do_op(1, 2'd0, 2'd0, 0, 2'd2, 0, 32'h100, 0, 4'd0, 0, 4'd1, 4'd2,
          32'h1122_3344, 1, 1'b0);
    // R11: load into its own written-back base
    do_op(1, 2'd1, 2'd0, 0, 2'd2, 0, 32'h200, 0, 4'd4, 0, 4'd5, 4'd5,
          32'hCAFE_F00D, 0, 1'b0);
    do_op(1, 2'd2, 2'd1, 1, 2'd0, 1, 32'h203, 32'h8, 4'd0, 0, 4'd6, 4'd6,
          32'h80FF_0102, 2, 1'b0);
    // R11: same register but no writeback, and a store
    do_op(1, 2'd0, 2'd0, 0, 2'd1, 1, 32'h302, 0, 4'd2, 0, 4'd7, 4'd7,
          32'h8001_7FFF, 0, 1'b0);
    do_op(0, 2'd1, 2'd0, 0, 2'd2, 0, 32'h400, 0, 4'd8, 0, 4'd3, 4'd3,
          32'h0, 1, 1'b0);
    // R1 R4 R6: spare codes (mode 3, offset source 3, size 3) and wrap-around
    do_op(1, 2'd3, 2'd3, 0, 2'd3, 1, 32'hFFFF_FFF0, 32'h3, 4'd0, 5'd4, 4'd1, 4'd2,
          32'hDEAD_BEEF, 0, 1'b0);
    do_op(1, 2'd1, 2'd0, 1, 2'd1, 1, 32'h0000_0002, 0, 4'hF, 0, 4'd1, 4'd2,
          32'h9234_5678, 0, 1'b0);
    done = 1'b1;
  end

  initial begin : finisher
    for (int t = 0; t < 200000 && !done; t++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule